// File: doc/BRIEF.md
# Pending-Table Migration Engine

This engine transfers every pending interrupt bit from one redistributor's pending table in memory into another redistributor's pending table. A controller supplies the two table base addresses, whether each side has message-based interrupts switched on, each side's ID-width field and a global ID-width cap. It then pulses `start`. The engine walks both tables one byte at a time through a single byte-wide memory port.

When a source byte is nonzero, the engine folds it into the matching destination byte and then clears it at the source. Bits that are already pending at the destination are kept. When the walk is over, the engine asks both redistributors to recompute their highest pending interrupt. The walk skips the identifier range below the first message-based interrupt, so it never touches that part of either table.

Top module: `pend_migrate_engine`

## Requirements
- R1: If `src_en` or `dst_en` is 0 when `start` is taken, the engine issues no memory request and no notify pulse, and `done` is high in the first cycle after the start edge.
- R2: The effective ID width W is the smallest of `src_idbits`, `dst_idbits` and `lim_idbits`.
- R3: Only byte indices from 1024 (first message-based ID 8192 divided by 8) up to but excluding 2^(W+1)/8 are accessed. The address of index i is base + i. Bytes outside that range are left unchanged in both tables.
- R4: A zero source byte causes no destination read and no write of any kind.
- R5: A nonzero source byte S is handled as four accesses in this order: read S, read destination D, write 0 to the source, write D|S to the destination.
- R6: After an enabled start, `notify_src` and `notify_dst` are high together for exactly one cycle, and that cycle is the one just before `done`.
- R7: `busy` is high from the cycle after the start edge up to and including the single-cycle `done` pulse, and is low in the following cycle and whenever the engine is idle after reset.
- R8: A `start` pulse that arrives while `busy` is high is ignored, and the walk in progress completes unchanged.
- R9: A memory request is held with a stable address, direction and write data until `mem_req_ready` is seen. Only one request is outstanding at a time, and `mem_rsp_valid` completes it. The request line is low after reset.
- R10: If 2^(W+1)/8 is at most 1024, an enabled start makes no memory access but still produces the notify pulse and then `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a migration (taken only when idle) |
| src_en | input | 1 | Message-based interrupts enabled on the source side |
| dst_en | input | 1 | Message-based interrupts enabled on the destination side |
| src_base | input | ADDR_W | Source pending-table base, already masked |
| dst_base | input | ADDR_W | Destination pending-table base, already masked |
| src_idbits | input | IDB_W | Source ID-width field |
| dst_idbits | input | IDB_W | Destination ID-width field |
| lim_idbits | input | IDB_W | Global ID-width cap |
| busy | output | 1 | Migration in progress |
| done | output | 1 | Single-cycle completion pulse |
| notify_src | output | 1 | Source must re-evaluate its pending state |
| notify_dst | output | 1 | Destination must re-evaluate its pending state |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_rdata | input | 8 | Read data |

## Verification
For a disabled start, `done` is due one cycle after the start edge, so the bench samples at the first falling edge after it. For an enabled start, the bench samples at every falling edge while the engine runs. The notify pair must be seen exactly one sample before `done`, `busy` must stay high up to `done`, and `busy` must be low one sample after it. Table contents, access counts and access order are checked only after `done`. By then every write has been acknowledged, because the engine does not leave an access state until its response arrives. The memory model varies ready and response delays at random, so the same expectations hold under different handshake timing.

// File: rtl/pmig_pkg.sv
package pmig_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_WR_SRC,
    ST_WR_DST,
    ST_NEXT,
    ST_NOTIFY,
    ST_DONE
  } pmig_state_e;
endpackage

// File: rtl/pmig_span.sv
module pmig_span #(
  parameter int IDB_W = 5,
  parameter int IDX_W = 30
) (
  input  logic [IDB_W-1:0] src_idbits,
  input  logic [IDB_W-1:0] dst_idbits,
  input  logic [IDB_W-1:0] lim_idbits,
  output logic [IDX_W-1:0] end_idx
);
  localparam int SIZE_W = (1 << IDB_W) + 1;

  logic [IDB_W-1:0]  eff;
  logic [IDB_W:0]    shamt;
  logic [SIZE_W-1:0] size_bits;

  always_comb begin
    eff = src_idbits;
    if (dst_idbits < eff) eff = dst_idbits;
    if (lim_idbits < eff) eff = lim_idbits;
    shamt     = {1'b0, eff} + {{IDB_W{1'b0}}, 1'b1};
    size_bits = SIZE_W'(1) << shamt;
    end_idx   = IDX_W'(size_bits >> 3);
  end
endmodule

// File: rtl/pmig_port.sv
module pmig_port #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic              acc_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid
);
  logic issued_q, issued_d;

  always_comb begin
    mem_req_valid = acc_req && !issued_q;
    mem_req_write = acc_write;
    mem_req_addr  = acc_addr;
    mem_req_wdata = acc_wdata;
    acc_done      = issued_q && mem_rsp_valid;
    issued_d      = issued_q;
    if (mem_req_valid && mem_req_ready) issued_d = 1'b1;
    else if (acc_done)                  issued_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issued_q <= 1'b0;
    else        issued_q <= issued_d;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));
endmodule

// File: rtl/pmig_fsm.sv
module pmig_fsm
  import pmig_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 30,
  parameter int FIRST_IDX = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              src_en,
  input  logic              dst_en,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [IDX_W-1:0]  end_idx,
  input  logic              acc_done,
  input  logic [7:0]        acc_rdata,
  output logic              acc_req,
  output logic              acc_write,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [7:0]        acc_wdata,
  output logic              busy,
  output logic              done,
  output logic              notify
);
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(FIRST_IDX);

  pmig_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, end_q;
  logic [ADDR_W-1:0] sbase_q, dbase_q;
  logic [7:0]        sbyte_q, dbyte_q;
  logic              idx_en, cap_en, sbyte_en, dbyte_en;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q + IDX_W'(1);
    idx_en   = 1'b0;
    cap_en   = 1'b0;
    sbyte_en = 1'b0;
    dbyte_en = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        cap_en = 1'b1;
        idx_en = 1'b1;
        idx_d  = FIRST;
        if (!(src_en && dst_en))  state_d = ST_DONE;
        else if (end_idx <= FIRST) state_d = ST_NOTIFY;
        else                       state_d = ST_RD_SRC;
      end
      ST_RD_SRC: if (acc_done) begin
        if (acc_rdata == 8'h00) state_d = ST_NEXT;
        else begin
          sbyte_en = 1'b1;
          state_d  = ST_RD_DST;
        end
      end
      ST_RD_DST: if (acc_done) begin
        dbyte_en = 1'b1;
        state_d  = ST_WR_SRC;
      end
      ST_WR_SRC: if (acc_done) state_d = ST_WR_DST;
      ST_WR_DST: if (acc_done) state_d = ST_NEXT;
      ST_NEXT: begin
        idx_en  = 1'b1;
        state_d = (idx_d >= end_q) ? ST_NOTIFY : ST_RD_SRC;
      end
      ST_NOTIFY: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      end_q   <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
      sbyte_q <= '0;
      dbyte_q <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en)   idx_q   <= idx_d;
      if (cap_en) begin
        end_q   <= end_idx;
        sbase_q <= src_base;
        dbase_q <= dst_base;
      end
      if (sbyte_en) sbyte_q <= acc_rdata;
      if (dbyte_en) dbyte_q <= acc_rdata;
    end
  end

  always_comb begin
    acc_req   = (state_q == ST_RD_SRC) || (state_q == ST_RD_DST) ||
                (state_q == ST_WR_SRC) || (state_q == ST_WR_DST);
    acc_write = (state_q == ST_WR_SRC) || (state_q == ST_WR_DST);
    acc_addr  = ((state_q == ST_RD_SRC) || (state_q == ST_WR_SRC))
                ? sbase_q + ADDR_W'(idx_q) : dbase_q + ADDR_W'(idx_q);
    acc_wdata = (state_q == ST_WR_DST) ? (dbyte_q | sbyte_q) : 8'h00;
    busy      = (state_q != ST_IDLE);
    done      = (state_q == ST_DONE);
    notify    = (state_q == ST_NOTIFY);
  end

  // R6
  notify_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> done);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R4
  dst_read_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_DST) |-> (sbyte_q != 8'h00));
endmodule

// File: rtl/pend_migrate_engine.sv
module pend_migrate_engine #(
  parameter int ADDR_W   = 32,
  parameter int IDB_W    = 5,
  parameter int FIRST_ID = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              src_en,
  input  logic              dst_en,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [IDB_W-1:0]  src_idbits,
  input  logic [IDB_W-1:0]  dst_idbits,
  input  logic [IDB_W-1:0]  lim_idbits,
  output logic              busy,
  output logic              done,
  output logic              notify_src,
  output logic              notify_dst,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_rdata
);
  localparam int IDX_W     = (1 << IDB_W) - 2;
  localparam int FIRST_IDX = FIRST_ID / 8;

  logic [IDX_W-1:0]  end_idx;
  logic              acc_req, acc_write, acc_done, notify;
  logic [ADDR_W-1:0] acc_addr;
  logic [7:0]        acc_wdata;

  pmig_span #(.IDB_W(IDB_W), .IDX_W(IDX_W)) u_span (
    .src_idbits(src_idbits),
    .dst_idbits(dst_idbits),
    .lim_idbits(lim_idbits),
    .end_idx   (end_idx)
  );

  pmig_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FIRST_IDX(FIRST_IDX)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .src_en   (src_en),
    .dst_en   (dst_en),
    .src_base (src_base),
    .dst_base (dst_base),
    .end_idx  (end_idx),
    .acc_done (acc_done),
    .acc_rdata(mem_rsp_rdata),
    .acc_req  (acc_req),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .acc_wdata(acc_wdata),
    .busy     (busy),
    .done     (done),
    .notify   (notify)
  );

  pmig_port #(.ADDR_W(ADDR_W)) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_req      (acc_req),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata),
    .acc_done     (acc_done),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid)
  );

  assign notify_src = notify;
  assign notify_dst = notify;

  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);
endmodule

// File: tb/pend_migrate_engine_tb.sv
module pend_migrate_engine_tb;
  localparam int ADDR_W = 32;
  localparam int IDB_W  = 5;
  localparam int TBL    = 4096;
  localparam int FIRST  = 1024;
  localparam logic [31:0] SB = 32'h0001_0000;
  localparam logic [31:0] DB = 32'h0002_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, src_en = 1'b0, dst_en = 1'b0;
  logic [ADDR_W-1:0] src_base = '0, dst_base = '0;
  logic [IDB_W-1:0] src_idbits = '0, dst_idbits = '0, lim_idbits = '0;
  logic busy, done, notify_src, notify_dst;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_rdata = 8'h00;

  always #10 clk = ~clk;

  pend_migrate_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_en(src_en), .dst_en(dst_en),
    .src_base(src_base), .dst_base(dst_base), .src_idbits(src_idbits),
    .dst_idbits(dst_idbits), .lim_idbits(lim_idbits), .busy(busy), .done(done),
    .notify_src(notify_src), .notify_dst(notify_dst),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] mem [int unsigned];
  logic [7:0] exp_mem [int unsigned];

  int n_rd, n_wr, n_oor, n_order, walk_end;
  int last_kind, last_idx;
  bit pend, p_wr;
  int dly;
  logic [31:0] p_addr;
  logic [7:0] p_wdata;

  function automatic logic [7:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rde(input logic [31:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
  endfunction
  function automatic int eff_w(input int a, input int b, input int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction
  function automatic int end_of(input int w);
    return int'((64'd1 << (w + 1)) / 8);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model: random ready, 0..2 cycle response delay
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      pend = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_req_ready = 1'b0;
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          if (p_wr) mem[p_addr] = p_wdata;
          else      mem_rsp_rdata = rd(p_addr);
          pend = 1'b0;
        end else dly--;
      end else if (mem_req_valid) begin
        mem_req_ready = ($urandom % 4) != 0;
        if (mem_req_ready) begin
          int kind, idx;
          bit is_src;
          pend = 1'b1; dly = int'($urandom % 3);
          p_wr = mem_req_write; p_addr = mem_req_addr; p_wdata = mem_req_wdata;
          is_src = (p_addr >= SB) && (p_addr < SB + 8192);
          idx = is_src ? int'(p_addr - SB) : int'(p_addr - DB);
          if (!is_src && !((p_addr >= DB) && (p_addr < DB + 8192))) n_oor++;
          else if (idx < FIRST || idx >= walk_end) n_oor++;
          kind = {p_wr, is_src ? 1'b0 : 1'b1};
          if (p_wr) n_wr++; else n_rd++;
          if (kind == 1 && !(last_kind == 0 && last_idx == idx)) n_order++;
          if (kind == 2 && !(last_kind == 1 && last_idx == idx && p_wdata == 8'h00)) n_order++;
          if (kind == 3 && !(last_kind == 2 && last_idx == idx)) n_order++;
          last_kind = kind; last_idx = idx;
        end
      end else mem_req_ready = 1'b0;
    end
  end

  task automatic run_case(input string tag, input bit se, input bit de,
                          input int si, input int di, input int li, input bit mid);
    int w, e, lo, nnz, walked, n, nfy_cnt, nfy_mis, gap, mism_s, mism_d;
    bit nfy_last, nfy_before, got;
    mem.delete();
    for (int i = 0; i < TBL; i++) begin
      if ($urandom % 6 == 0) mem[SB + i] = 8'(($urandom % 255) + 1);
      if ($urandom % 4 == 0) mem[DB + i] = 8'(($urandom % 255) + 1);
    end
    mem[SB + 1023] = 8'hA5;
    mem[SB + 1024] = 8'h81;
    mem[DB + 1024] = 8'h18;
    mem[SB + 2048] = 8'h3C;
    mem[SB + 4095] = 8'h5A;
    w = eff_w(si, di, li);
    e = end_of(w);
    walk_end = (se && de) ? e : FIRST;
    exp_mem = mem;
    nnz = 0;
    walked = 0;
    if (se && de) for (int i = FIRST; i < e; i++) begin
      walked++;
      if (rd(SB + i) != 8'h00) begin
        nnz++;
        exp_mem[DB + i] = rd(DB + i) | rd(SB + i);
        exp_mem[SB + i] = 8'h00;
      end
    end
    n_rd = 0; n_wr = 0; n_oor = 0; n_order = 0; last_kind = -1; last_idx = -1;
    @(negedge clk);
    src_en = se; dst_en = de; src_base = SB; dst_base = DB;
    src_idbits = IDB_W'(si); dst_idbits = IDB_W'(di); lim_idbits = IDB_W'(li);
    start = 1'b1;
    n = 0; nfy_cnt = 0; nfy_mis = 0; gap = 0; nfy_last = 0; nfy_before = 0; got = 0;
    while (!got && n < 60000) begin
      @(negedge clk);
      n++;
      if (mid && n == 6) begin
        start = 1'b1; src_en = 1'b0; src_base = DB; dst_base = SB;
      end else start = 1'b0;
      if (!busy) gap++;
      if (notify_src != notify_dst) nfy_mis++;
      if (notify_src) nfy_cnt++;
      if (done) begin got = 1; nfy_before = nfy_last; end
      nfy_last = notify_src;
    end
    start = 1'b0;
    chk(got, "R7", {tag, " done seen"}, got, 1);
    chk(gap == 0, "R7", {tag, " busy low before done"}, gap, 0);
    if (!(se && de)) begin
      chk(n == 1, "R1", {tag, " done latency"}, n, 1);
      chk(nfy_cnt == 0, "R1", {tag, " notify count"}, nfy_cnt, 0);
      chk(n_rd + n_wr == 0, "R1", {tag, " memory accesses"}, n_rd + n_wr, 0);
    end else begin
      chk(nfy_cnt == 1 && nfy_mis == 0, "R6", {tag, " notify pair once"}, nfy_cnt, 1);
      chk(nfy_before, "R6", {tag, " notify just before done"}, nfy_before, 1);
      if (walked == 0)
        chk(n_rd + n_wr == 0, "R10", {tag, " empty range accesses"}, n_rd + n_wr, 0);
      chk(n_rd == walked + nnz, "R4", {tag, " read count"}, n_rd, walked + nnz);
      chk(n_wr == 2 * nnz, "R4", {tag, " write count"}, n_wr, 2 * nnz);
      chk(n_order == 0, "R5", {tag, " access order"}, n_order, 0);
    end
    chk(n_oor == 0, "R3", {tag, " out-of-range accesses"}, n_oor, 0);
    @(negedge clk);
    chk(!busy && !done, "R7", {tag, " idle after done"}, {busy, done}, 0);
    lo = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || busy) lo++;
    end
    chk(lo == 0, "R8", {tag, " no second run"}, lo, 0);
    mism_s = 0; mism_d = 0;
    for (int i = 0; i < TBL; i++) begin
      if (rd(SB + i) != rde(SB + i)) mism_s++;
      if (rd(DB + i) != rde(DB + i)) mism_d++;
    end
    chk(mism_s == 0, "R5", {tag, " source table"}, mism_s, 0);
    chk(mism_d == 0, "R5", {tag, " destination table (R2 range)"}, mism_d, 0);
    chk(rd(SB + 1023) == 8'hA5, "R3", {tag, " byte below range kept"}, rd(SB + 1023), 8'hA5);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !notify_src && !notify_dst, "R7", "reset outputs",
        {busy, done, notify_src, notify_dst}, 0);
    chk(!mem_req_valid, "R9", "reset request", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req_valid, "R7", "idle after reset", busy, 0);
    run_case("src disabled", 1'b0, 1'b1, 14, 14, 14, 1'b0);   // R1
    run_case("dst disabled", 1'b1, 1'b0, 14, 14, 14, 1'b0);   // R1
    run_case("src min", 1'b1, 1'b1, 13, 14, 15, 1'b1);        // R2 R8
    run_case("dst min", 1'b1, 1'b1, 14, 13, 15, 1'b0);        // R2
    run_case("limit min", 1'b1, 1'b1, 14, 14, 13, 1'b0);      // R2 R3
    run_case("full width", 1'b1, 1'b1, 14, 15, 14, 1'b0);     // R3 last byte
    run_case("empty range", 1'b1, 1'b1, 12, 14, 15, 1'b0);    // R10
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule